// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a 3-bit synchronous counter that, on each clock edge where its count input is high, moves through a fixed loop of five codes that do not follow binary order: 000, 010, 011, 101, 110, then back to 000. The present state is the output itself. Bit 2 is the most significant bit and bit 0 the least significant. No separate output decode stands between the state and the pins.

Three of the eight 3-bit codes (001, 100, 111) are not on the loop. Each one has a defined successor, so the counter finds its way into the loop within two counting steps from any value it might hold after power-up. A synchronous active-high reset forces 000. A load port writes any code, including the off-loop ones, so that recovery can be exercised. A parameter selects how the state is held inside the block: a 3-bit binary register driven by minimal next-state equations, or an 8-bit one-hot register with one flop per code. Both settings produce the same code sequence at the port.

Top module: `seq5_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `code` becomes 000 after that edge, whatever `ld_en` and `cnt_en` are doing.
- R2: With `rst` and `ld_en` low and `cnt_en` high, one edge moves `code` along the loop 000→010→011→101→110→000.
- R3: With `rst`, `ld_en` and `cnt_en` all low, `code` does not change across an edge.
- R4: A counting step taken from any of the five loop codes never lands on 001, 100 or 111.
- R5: A counting step from an off-loop code goes 001→110, 100→010 and 111→100.
- R6: Starting from any of the eight codes, at most two counting steps bring `code` onto the loop.
- R7: With `rst` low and `ld_en` high, `code` takes the value of `ld_val` after the edge; the load wins over `cnt_en`.
- R8: The one-hot setting of `ENC` (ENC_HOT) gives the same `code` as the binary setting (ENC_BIN) for every input sequence, and its internal register always has exactly one bit set after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to 000 |
| cnt_en | input | 1 | Count enable; high steps the counter one code |
| ld_en | input | 1 | Load strobe; high writes `ld_val` into the state |
| ld_val | input | 3 | Code written on a load, any of the eight values |
| code | output | 3 | Present state, bit 2 most significant |

## Verification
The bench builds two copies of the counter side by side, one with `ENC` at ENC_BIN and one at ENC_HOT. Every check is applied to both copies, which puts the equation-based next-state logic and the table-derived one-hot network under the same stimulus. The load port brings all three off-loop codes within reach from either setting, so the recovery paths and the two-step bound are exercised for each encoding. It also lets the bench check the ordering between reset, load and count.

// File: rtl/seq5_pkg.sv
package seq5_pkg;

    localparam int CODE_W  = 3;
    localparam int N_CODES = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_HOME = code_t'(0);

    // Internal encoding choice for the state register.
    typedef enum logic {
        ENC_BIN = 1'b0,
        ENC_HOT = 1'b1
    } enc_e;

    // Decoded action for one clock edge; reset > load > step > hold.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        op_e   op;
        code_t val;
    } cmd_t;

    // Successor of every code, written as a table (used to build
    // the one-hot network and for checks).
    function automatic code_t succ_of(code_t s);
        code_t n;
        case (s)
            3'b000:  n = 3'b010;
            3'b010:  n = 3'b011;
            3'b011:  n = 3'b101;
            3'b101:  n = 3'b110;
            3'b110:  n = 3'b000;
            3'b001:  n = 3'b110;
            3'b100:  n = 3'b010;
            default: n = 3'b100;
        endcase
        return n;
    endfunction

    function automatic logic on_loop(code_t s);
        return (s == 3'b000) || (s == 3'b010) || (s == 3'b011) ||
               (s == 3'b101) || (s == 3'b110);
    endfunction

endpackage

// File: rtl/seq5_ctrl.sv
module seq5_ctrl
    import seq5_pkg::*;
(
    input  logic  rst,
    input  logic  cnt_en,
    input  logic  ld_en,
    input  code_t ld_val,
    output cmd_t  cmd
);

    always_comb begin
        cmd.val = ld_val;
        if (rst)
            cmd.op = OP_CLEAR;
        else if (ld_en)
            cmd.op = OP_LOAD;
        else if (cnt_en)
            cmd.op = OP_STEP;
        else
            cmd.op = OP_HOLD;
    end

endmodule

// File: rtl/seq5_state_bin.sv
module seq5_state_bin
    import seq5_pkg::*;
(
    input  logic  clk,
    input  cmd_t  cmd,
    output code_t state
);

    code_t st_q;
    code_t st_nx;
    logic  c_b, b_b, a_b;

    assign c_b = st_q[2];
    assign b_b = st_q[1];
    assign a_b = st_q[0];

    // Minimal equations; off-loop codes fall out of the same terms.
    always_comb begin
        st_nx[2] = a_b;
        st_nx[1] = ~b_b | (~a_b & ~c_b);
        st_nx[0] = b_b & ~c_b;
    end

    always_ff @(posedge clk) begin
        unique case (cmd.op)
            OP_CLEAR: st_q <= CODE_HOME;
            OP_LOAD:  st_q <= cmd.val;
            OP_STEP:  st_q <= st_nx;
            default:  st_q <= st_q;
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/seq5_state_hot.sv
module seq5_state_hot
    import seq5_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cmd_t  cmd,
    output code_t state
);

    logic [N_CODES-1:0] hot_q;
    logic [N_CODES-1:0] hot_nx;
    logic [N_CODES-1:0] hot_ld;

    // Each set bit forwards to the bit of its successor code.
    always_comb begin
        hot_nx = '0;
        for (int i = 0; i < N_CODES; i++) begin
            if (hot_q[i])
                hot_nx[succ_of(code_t'(i))] = 1'b1;
        end
    end

    always_comb begin
        hot_ld = '0;
        hot_ld[cmd.val] = 1'b1;
    end

    always_ff @(posedge clk) begin
        unique case (cmd.op)
            OP_CLEAR: hot_q <= N_CODES'(1) << CODE_HOME;
            OP_LOAD:  hot_q <= hot_ld;
            OP_STEP:  hot_q <= hot_nx;
            default:  hot_q <= hot_q;
        endcase
    end

    // Encode the single set bit back to a 3-bit code.
    always_comb begin
        state = '0;
        for (int i = 0; i < N_CODES; i++) begin
            if (hot_q[i])
                state = state | code_t'(i);
        end
    end

    // R8: exactly one flop set once reset has been seen
    a_r8_single_hot: assert property (@(posedge clk) disable iff (rst)
        $past(rst) || $past(cmd.op) != OP_CLEAR |-> $countones(hot_q) == 1);

endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
    import seq5_pkg::*;
#(
    parameter enc_e ENC = ENC_BIN
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cnt_en,
    input  logic                   ld_en,
    input  logic [CODE_W-1:0]      ld_val,
    output logic [CODE_W-1:0]      code
);

    cmd_t  cmd;
    code_t state;

    seq5_ctrl u_ctrl (
        .rst    (rst),
        .cnt_en (cnt_en),
        .ld_en  (ld_en),
        .ld_val (ld_val),
        .cmd    (cmd)
    );

    generate
        if (ENC == ENC_HOT) begin : g_hot
            seq5_state_hot u_state (
                .clk   (clk),
                .rst   (rst),
                .cmd   (cmd),
                .state (state)
            );
        end else begin : g_bin
            seq5_state_bin u_state (
                .clk   (clk),
                .cmd   (cmd),
                .state (state)
            );
        end
    endgenerate

    assign code = state;

    // R1: reset lands on 000 regardless of load and count
    a_r1_reset_home: assert property (@(posedge clk)
        rst |=> code == 3'b000);

    // R2: two sample loop arcs, including the wrap
    a_r2_arc_101: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && cnt_en && code == 3'b101) |=> code == 3'b110);
    a_r2_wrap_110: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && cnt_en && code == 3'b110) |=> code == 3'b000);

    // R3: no enable, no load -> state held
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !cnt_en) |=> $stable(code));

    // R4: the loop is closed under counting
    a_r4_stay_on_loop: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && cnt_en && on_loop(code)) |=> on_loop(code));

    // R5: recovery arc of the deepest off-loop code
    a_r5_111_to_100: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && cnt_en && code == 3'b111) |=> code == 3'b100);

    // R7: load takes the presented value
    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> code == $past(ld_val));

endmodule

// File: tb/seq5_counter_bench.sv
module seq5_counter_bench;
    import seq5_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 17;
    localparam int WDOG_CYC   = 5000;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  cnt_en = 1'b0;
    logic  ld_en = 1'b0;
    code_t ld_val = '0;
    code_t code_b, code_h;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq5_counter #(.ENC(ENC_BIN)) u_seq5_counter (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld_en(ld_en),
        .ld_val(ld_val), .code(code_b));

    seq5_counter #(.ENC(ENC_HOT)) u_seq5_counter_hot (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld_en(ld_en),
        .ld_val(ld_val), .code(code_h));

    // Vector fields: {rst, ld_en, ld_val[2:0], cnt_en, expected[2:0]}
    localparam logic [8:0] VEC [N_VEC] = '{
        {1'b1, 1'b0, 3'd0, 1'b0, 3'b000},  // R1 reset
        {1'b0, 1'b0, 3'd0, 1'b1, 3'b010},  // R2
        {1'b0, 1'b0, 3'd0, 1'b1, 3'b011},  // R2
        {1'b0, 1'b0, 3'd0, 1'b0, 3'b011},  // R3 hold
        {1'b0, 1'b0, 3'd0, 1'b1, 3'b101},  // R2
        {1'b0, 1'b0, 3'd0, 1'b1, 3'b110},  // R2
        {1'b0, 1'b0, 3'd0, 1'b1, 3'b000},  // R2 wrap
        {1'b0, 1'b0, 3'd0, 1'b1, 3'b010},  // R2
        {1'b0, 1'b1, 3'd7, 1'b0, 3'b111},  // R7 load
        {1'b0, 1'b0, 3'd0, 1'b1, 3'b100},  // R5
        {1'b0, 1'b0, 3'd0, 1'b1, 3'b010},  // R5
        {1'b0, 1'b1, 3'd1, 1'b1, 3'b001},  // R7 load beats count
        {1'b0, 1'b0, 3'd0, 1'b1, 3'b110},  // R5
        {1'b1, 1'b1, 3'd5, 1'b1, 3'b000},  // R1 reset beats all
        {1'b0, 1'b1, 3'd4, 1'b0, 3'b100},  // R7
        {1'b0, 1'b0, 3'd0, 1'b0, 3'b100},  // R3 hold off-loop
        {1'b0, 1'b0, 3'd0, 1'b1, 3'b010}   // R5
    };

    task automatic chk(input string tag, input code_t exp);
        checks++;
        if (code_b !== exp) begin
            failures++;
            $display("FAIL %s bin: got %b expected %b", tag, code_b, exp);
        end
        checks++;
        if (code_h !== exp || code_h !== code_b) begin
            failures++;
            $display("FAIL %s R8 hot: got %b expected %b", tag, code_h, exp);
        end
    endtask

    // Drive just after an edge, let one edge pass, sample 1 unit later.
    task automatic apply(input logic r, input logic l, input code_t v,
                         input logic c);
        rst = r; ld_en = l; ld_val = v; cnt_en = c;
        @(posedge clk);
        #1;
    endtask

    function automatic code_t model_succ(code_t s);
        case (s)
            3'b000: return 3'b010;
            3'b010: return 3'b011;
            3'b011: return 3'b101;
            3'b101: return 3'b110;
            3'b110: return 3'b000;
            3'b001: return 3'b110;
            3'b100: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic bit model_loop(code_t s);
        return s == 3'b000 || s == 3'b010 || s == 3'b011 ||
               s == 3'b101 || s == 3'b110;
    endfunction

    initial begin
        @(posedge clk);
        #1;
        chk("R1 initial reset", 3'b000);

        for (int k = 0; k < N_VEC; k++) begin
            logic [8:0] v;
            v = VEC[k];
            apply(v[8], v[7], v[6:4], v[3]);
            chk($sformatf("vector %0d (R1/R2/R3/R5/R7)", k), v[2:0]);
        end

        // R6: every code reaches the loop in two steps; R5/R4 along the way
        for (int s = 0; s < N_CODES; s++) begin
            code_t cur, n1, n2;
            cur = code_t'(s);
            n1  = model_succ(cur);
            n2  = model_succ(n1);
            apply(1'b0, 1'b1, cur, 1'b0);
            chk("R7 preload", cur);
            apply(1'b0, 1'b0, 3'd0, 1'b1);
            chk(model_loop(cur) ? "R4 first step" : "R5 first step", n1);
            apply(1'b0, 1'b0, 3'd0, 1'b1);
            chk("R6 second step", n2);
            checks++;
            if (!model_loop(code_b) || !model_loop(code_h)) begin
                failures++;
                $display("FAIL R6 from %b: got %b/%b expected on-loop code",
                         cur, code_b, code_h);
            end
        end

        // R3: long hold with count low
        apply(1'b0, 1'b1, 3'b011, 1'b0);
        for (int i = 0; i < 4; i++) begin
            apply(1'b0, 1'b0, 3'b101, 1'b0);
            chk("R3 hold ignores ld_val", 3'b011);
        end

        // R1: reset during a load with count high
        apply(1'b1, 1'b1, 3'b111, 1'b1);
        chk("R1 reset over load", 3'b000);

        // R2: full loop twice from home
        for (int i = 0; i < 10; i++) begin
            code_t e;
            e = model_succ(code_b);
            apply(1'b0, 1'b0, 3'd0, 1'b1);
            chk("R2 loop walk", e);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule